// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the word-address stream for a single DMA channel. Software loads a start word address, a line length, a line stride and a line count, then pulses `start`. The sequencer walks the programmed pattern and offers one address per accepted request on a valid/ready handshake. A downstream bus master turns each address into a bus transfer. The direction and burst settings captured at launch travel with the stream as plain flags.

A non-zero line length selects a strided two-dimensional transfer. The channel emits `line_count + 1` lines of `line_len` words each, and each line begins `stride` words after the start of the line before it. A single completion pulse marks the end, and the channel then returns to idle. A line length of zero selects ring mode. In ring mode the address runs over a region of `stride * (line_count + 1)` words and wraps back to the start without end. An event pulse marks the end of each half of that region. `abort` stops the channel in either mode.

Top module: `dma2d_addr_seq`

## Requirements
- R1: After reset `req_valid`, `done_pulse` and `half_pulse` are 0.
- R2: A `start` pulse while idle captures the configuration. From the next cycle, `req_valid` is 1, `req_addr` equals the start word address, and `req_dir` and `req_burst` show the captured direction (1 = memory to device, 0 = device to memory) and burst bit (1 = four-word requests).
- R3: With a non-zero line length, a line presents the addresses line base + 0, + step, + 2·step and so on, up to line base + line_len − step. The step is 1, or 4 in burst mode.
- R4: Each new line's base is the previous base plus `stride`, and exactly `line_count + 1` lines are produced (a count of 0 means one line).
- R5: `done_pulse` is high for exactly one cycle, in the cycle after the last address of the last line is accepted. In that same cycle `req_valid` is 0.
- R6: With a line length of 0 (ring mode), the address is start + offset. The offset advances by the step on each accepted request and returns to 0 after reaching `stride*(line_count+1) − step`.
- R7: In ring mode `half_pulse` is high for one cycle after the request that completes the first half of the region is accepted, and again after the request that completes the whole region is accepted. `done_pulse` never rises in ring mode.
- R8: In burst mode every accepted request covers four words: successive addresses within a line differ by 4 (line length and, in ring mode, half the region must be multiples of 4).
- R9: While `req_valid` is 1 and `req_ready` is 0, `req_addr` stays unchanged on the next cycle.
- R10: In the cycle `abort` is high, `req_valid` is 0, so no request is accepted. From the next cycle the channel is idle, and no done or half event is produced for that cycle.
- R11: A `start` pulse while the channel is running has no effect. The running address sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_addr | input | AW | Start word address (byte address / 4) |
| cfg_line_len | input | LW | Words per line; 0 selects ring mode |
| cfg_stride | input | LW | Words from one line start to the next |
| cfg_line_count | input | CW | Number of lines minus one |
| cfg_dir | input | 1 | 1 = memory to device, 0 = device to memory |
| cfg_burst | input | 1 | 1 = four-word requests |
| start | input | 1 | Launch pulse, honoured only when idle |
| abort | input | 1 | Stop pulse, any state |
| req_valid | output | 1 | Address request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | AW | Requested word address |
| req_dir | output | 1 | Captured direction flag |
| req_burst | output | 1 | Captured burst flag |
| done_pulse | output | 1 | End of a two-dimensional transfer |
| half_pulse | output | 1 | Ring half-region boundary reached |

## Verification
Abort can coincide with the cycle that would carry the final handshake of a transfer, or with the handshake that closes a ring half. The bench provokes both cases. It raises `abort` together with `req_ready` exactly when the next offered address is the last of the transfer, or the last before a half boundary. It then judges that `req_valid` was low in that cycle and that neither `done_pulse` nor `half_pulse` appears in the following one. Backpressure patterns interleave ready-low cycles with the boundaries, so that stalls also land on line ends and wrap points.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   localparam int unsigned BEAT_WORDS = 4;
endpackage

// File: rtl/dma2d_fsm.sv
module dma2d_fsm
   import dma2d_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic fire,
   input  logic last_beat,
   output logic running,
   output logic load
);
   seq_state_e state_q, state_d;

   assign load    = (state_q == SEQ_IDLE) && start && !abort;
   assign running = (state_q == SEQ_RUN);

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_IDLE: if (load) state_d = SEQ_RUN;
         SEQ_RUN: begin
            if (abort)                  state_d = SEQ_IDLE;
            else if (fire && last_beat) state_d = SEQ_IDLE;
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !running);  // R10
   AST_RUN_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !abort && !(fire && last_beat)) |=> running);  // R11
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
   import dma2d_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned LW       = 16,
   parameter int unsigned CW       = 12,
   parameter bit          BURST_EN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          advance,
   input  logic [AW-1:0] cfg_start_addr,
   input  logic [LW-1:0] cfg_line_len,
   input  logic [LW-1:0] cfg_stride,
   input  logic [CW-1:0] cfg_line_count,
   input  logic          cfg_dir,
   input  logic          cfg_burst,
   output logic [AW-1:0] addr,
   output logic          dir_q,
   output logic          burst_q,
   output logic          last_beat,
   output logic          half_hit,
   output logic          wrap_hit
);
   localparam int unsigned RW = LW + CW;

   logic [AW-1:0] start_q, line_base_q;
   logic [LW-1:0] len_q, stride_q, col_q;
   logic [CW-1:0] cnt_q, row_q;
   logic [RW-1:0] region_q, half_q, ring_off_q;
   logic          ring_q;
   logic [2:0]    step_w;
   logic [LW:0]   col_sum;
   logic [RW:0]   ring_sum;
   logic          line_end;
   logic [RW-1:0] region_calc;

   generate
      if (BURST_EN) begin : g_burst_step
         assign step_w = burst_q ? 3'(BEAT_WORDS) : 3'd1;
      end else begin : g_single_step
         assign step_w = 3'd1;
      end
   endgenerate

   assign region_calc = RW'(cfg_stride) * (RW'(cfg_line_count) + RW'(1));

   assign col_sum   = {1'b0, col_q} + (LW+1)'(step_w);
   assign ring_sum  = {1'b0, ring_off_q} + (RW+1)'(step_w);
   assign line_end  = col_sum >= {1'b0, len_q};
   assign last_beat = !ring_q && line_end && (row_q == cnt_q);
   assign wrap_hit  = ring_q && (ring_sum >= {1'b0, region_q});
   assign half_hit  = ring_q && (ring_sum == {1'b0, half_q});
   assign addr      = ring_q ? (start_q + AW'(ring_off_q))
                             : (line_base_q + AW'(col_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q     <= '0;
         line_base_q <= '0;
         len_q       <= '0;
         stride_q    <= '0;
         cnt_q       <= '0;
         col_q       <= '0;
         row_q       <= '0;
         region_q    <= '0;
         half_q      <= '0;
         ring_off_q  <= '0;
         ring_q      <= 1'b0;
         dir_q       <= 1'b0;
         burst_q     <= 1'b0;
      end else if (load) begin
         start_q     <= cfg_start_addr;
         line_base_q <= cfg_start_addr;
         len_q       <= cfg_line_len;
         stride_q    <= cfg_stride;
         cnt_q       <= cfg_line_count;
         col_q       <= '0;
         row_q       <= '0;
         region_q    <= region_calc;
         half_q      <= region_calc >> 1;
         ring_off_q  <= '0;
         ring_q      <= (cfg_line_len == '0);
         dir_q       <= cfg_dir;
         burst_q     <= BURST_EN ? cfg_burst : 1'b0;
      end else if (advance) begin
         if (ring_q) begin
            ring_off_q <= wrap_hit ? '0 : ring_sum[RW-1:0];
         end else if (line_end) begin
            col_q       <= '0;
            line_base_q <= line_base_q + AW'(stride_q);
            row_q       <= row_q + CW'(1);
         end else begin
            col_q <= col_sum[LW-1:0];
         end
      end
   end

   AST_LOAD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr == $past(cfg_start_addr)));  // R2
   AST_RING_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      ring_q |-> !last_beat);  // R7
endmodule

// File: rtl/dma2d_events.sv
module dma2d_events (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic fire,
   input  logic last_beat,
   input  logic half_hit,
   input  logic wrap_hit,
   output logic done_pulse,
   output logic half_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_pulse <= 1'b0;
         half_pulse <= 1'b0;
      end else begin
         done_pulse <= fire && last_beat && !abort;
         half_pulse <= fire && (half_hit || wrap_hit) && !abort;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);  // R5
   AST_EVENTS_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_pulse && half_pulse));  // R7
endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq #(
   parameter int unsigned AW       = 32,
   parameter int unsigned LW       = 16,
   parameter int unsigned CW       = 12,
   parameter bit          BURST_EN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cfg_start_addr,
   input  logic [LW-1:0] cfg_line_len,
   input  logic [LW-1:0] cfg_stride,
   input  logic [CW-1:0] cfg_line_count,
   input  logic          cfg_dir,
   input  logic          cfg_burst,
   input  logic          start,
   input  logic          abort,
   output logic          req_valid,
   input  logic          req_ready,
   output logic [AW-1:0] req_addr,
   output logic          req_dir,
   output logic          req_burst,
   output logic          done_pulse,
   output logic          half_pulse
);
   generate
      if (AW < LW + CW) begin : g_bad_aw
         $error("AW must cover LW+CW bits of ring offset");
      end
      if (LW < 3) begin : g_bad_lw
         $error("LW must be at least 3");
      end
      if (CW < 1) begin : g_bad_cw
         $error("CW must be at least 1");
      end
   endgenerate

   logic running, load, fire;
   logic last_beat, half_hit, wrap_hit;

   assign req_valid = running && !abort;
   assign fire      = req_valid && req_ready;

   dma2d_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .abort     (abort),
      .fire      (fire),
      .last_beat (last_beat),
      .running   (running),
      .load      (load)
   );

   dma2d_walker #(
      .AW       (AW),
      .LW       (LW),
      .CW       (CW),
      .BURST_EN (BURST_EN)
   ) u_walker (
      .clk            (clk),
      .rst_n          (rst_n),
      .load           (load),
      .advance        (fire),
      .cfg_start_addr (cfg_start_addr),
      .cfg_line_len   (cfg_line_len),
      .cfg_stride     (cfg_stride),
      .cfg_line_count (cfg_line_count),
      .cfg_dir        (cfg_dir),
      .cfg_burst      (cfg_burst),
      .addr           (req_addr),
      .dir_q          (req_dir),
      .burst_q        (req_burst),
      .last_beat      (last_beat),
      .half_hit       (half_hit),
      .wrap_hit       (wrap_hit)
   );

   dma2d_events u_events (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (abort),
      .fire       (fire),
      .last_beat  (last_beat),
      .half_hit   (half_hit),
      .wrap_hit   (wrap_hit),
      .done_pulse (done_pulse),
      .half_pulse (half_pulse)
   );

   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> $stable(req_addr));  // R9
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!req_valid && !done_pulse && !half_pulse));  // R10
   AST_DONE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (!req_valid && $past(fire)));  // R5
endmodule

// File: tb/tb_dma2d_addr_seq.sv
module tb_dma2d_addr_seq;
   localparam int AW = 32;
   localparam int LW = 16;
   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_start_addr = '0;
   logic [LW-1:0] cfg_line_len = '0;
   logic [LW-1:0] cfg_stride = '0;
   logic [CW-1:0] cfg_line_count = '0;
   logic          cfg_dir = 1'b0;
   logic          cfg_burst = 1'b0;
   logic          start = 1'b0;
   logic          abort = 1'b0;
   logic          req_ready = 1'b0;
   logic          req_valid, req_dir, req_burst, done_pulse, half_pulse;
   logic [AW-1:0] req_addr;

   int   n_chk = 0;
   int   n_fail = 0;
   int   pi = 0;
   logic [7:0] pat = 8'hFF;

   always #5 clk = ~clk;

   dma2d_addr_seq dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_start_addr(cfg_start_addr), .cfg_line_len(cfg_line_len),
      .cfg_stride(cfg_stride), .cfg_line_count(cfg_line_count),
      .cfg_dir(cfg_dir), .cfg_burst(cfg_burst),
      .start(start), .abort(abort),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_dir(req_dir), .req_burst(req_burst),
      .done_pulse(done_pulse), .half_pulse(half_pulse)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Present one beat: entered just after a negedge, left at the negedge after the handshake.
   task automatic beat(input logic [31:0] exp, input string req);
      bit got = 0;
      while (!got) begin
         req_ready = pat[pi % 8];
         pi++;
         #1;
         chk(req_valid === 1'b1 && req_addr === exp, req, {31'd0, req_valid, req_addr}, {32'd1, exp});
         got = req_ready;
         @(negedge clk);
         start = 1'b0;
      end
      req_ready = 1'b0;
   endtask

   task automatic launch(input logic [31:0] s, input int len, input int stride, input int cnt,
                         input bit dir, input bit burst);
      @(negedge clk);
      cfg_start_addr = s;
      cfg_line_len   = LW'(len);
      cfg_stride     = LW'(stride);
      cfg_line_count = CW'(cnt);
      cfg_dir        = dir;
      cfg_burst      = burst;
      start          = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(req_valid === 1'b1, "R2 valid after start", {63'd0, req_valid}, 64'd1);
      chk(req_dir === dir && req_burst === burst, "R2 flags",
          {62'd0, req_dir, req_burst}, {62'd0, dir, burst});
   endtask

   task automatic t_reset();
      #1;
      chk(req_valid === 1'b0 && done_pulse === 1'b0 && half_pulse === 1'b0, "R1 reset outputs",
          {61'd0, req_valid, done_pulse, half_pulse}, 64'd0);
   endtask

   task automatic t_normal(input logic [31:0] s, input int len, input int stride, input int cnt,
                           input bit dir, input bit burst, input logic [7:0] p, input bit poke);
      int step = burst ? 4 : 1;
      pat = p;
      launch(s, len, stride, cnt, dir, burst);
      for (int row = 0; row <= cnt; row++) begin
         for (int col = 0; col < len; col += step) begin
            bit last = (row == cnt) && (col + step >= len);
            if (poke && row == 0 && col == step) begin
               cfg_start_addr = 32'hDEAD0;   // R11: ignored while running
               cfg_line_len   = 16'd1;
               start          = 1'b1;
            end
            beat(s + row * stride + col, burst ? "R8 burst address" : "R3 R4 line address");
            #1;
            chk(done_pulse === last, "R5 done timing", {63'd0, done_pulse}, {63'd0, last});
            if (last) chk(req_valid === 1'b0, "R5 idle after done", {63'd0, req_valid}, 64'd0);
         end
      end
      @(negedge clk);
      #1;
      chk(done_pulse === 1'b0 && req_valid === 1'b0, "R5 single pulse",
          {62'd0, done_pulse, req_valid}, 64'd0);
   endtask

   task automatic t_ring(input logic [31:0] s, input int stride, input int cnt, input bit burst,
                         input int nbeats);
      int step = burst ? 4 : 1;
      int region = stride * (cnt + 1);
      int off;
      bit ev;
      pat = 8'hB7;
      launch(s, 0, stride, cnt, 1'b0, burst);
      for (int k = 0; k < nbeats; k++) begin
         off = (k * step) % region;
         beat(s + off, "R6 ring address");
         #1;
         ev = (off + step == region / 2) || (off + step == region);
         chk(half_pulse === ev, "R7 half event", {63'd0, half_pulse}, {63'd0, ev});
         chk(done_pulse === 1'b0, "R7 no done in ring", {63'd0, done_pulse}, 64'd0);
      end
      // abort exactly when the offered beat would close a half
      req_ready = 1'b1;
      abort     = 1'b1;
      #1;
      chk(req_valid === 1'b0, "R10 valid low during abort", {63'd0, req_valid}, 64'd0);
      @(negedge clk);
      abort     = 1'b0;
      req_ready = 1'b0;
      #1;
      chk(req_valid === 1'b0 && half_pulse === 1'b0 && done_pulse === 1'b0,
          "R10 idle and no event after abort", {61'd0, req_valid, half_pulse, done_pulse}, 64'd0);
   endtask

   task automatic t_abort_last();
      pat = 8'hFF;
      launch(32'h3000, 2, 2, 0, 1'b1, 1'b0);
      beat(32'h3000, "R3 first word");
      req_ready = 1'b1;
      abort     = 1'b1;
      #1;
      chk(req_valid === 1'b0, "R10 abort on last beat", {63'd0, req_valid}, 64'd0);
      @(negedge clk);
      abort     = 1'b0;
      req_ready = 1'b0;
      #1;
      chk(done_pulse === 1'b0 && req_valid === 1'b0, "R10 done suppressed",
          {62'd0, done_pulse, req_valid}, 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_normal(32'h1000, 3, 5, 2, 1'b1, 1'b0, 8'hFF, 1'b0);
      t_normal(32'h2000, 4, 4, 0, 1'b0, 1'b0, 8'h5A, 1'b0);       // R9 stalls
      t_normal(32'h4000, 8, 12, 1, 1'b1, 1'b1, 8'hD3, 1'b0);      // R8
      t_normal(32'h5000, 3, 5, 1, 1'b0, 1'b0, 8'hFF, 1'b1);       // R11
      t_ring(32'h0100, 4, 1, 1'b0, 11);                            // R6 R7 R10
      t_ring(32'h0200, 8, 1, 1'b1, 5);                             // R8 ring
      t_abort_last();
      t_normal(32'h6000, 1, 3, 3, 1'b1, 1'b0, 8'hEE, 1'b0);       // restart after abort
      summary();
      $finish;
   end
endmodule